// File: doc/BRIEF.md
# Dual-Mode PRG/CHR Bank Mapper

This block computes the bank numbers a cartridge mapper presents to the memory system. It holds eleven 8-bit bank registers, a mode register and an outer-bank register, all loaded through a simple write port. From them it derives four 8 KB program-window bank numbers, eight 1 KB character-window bank numbers and a 2-bit nametable mirroring select. The ROMs, any timer and any interrupt sit outside the block.

Program space runs in one of two layouts. In the free layout, three registers each pick an 8 KB bank, and the top window always shows the last bank of the fitted ROM. In the paired layout, the outer-bank register selects two 16 KB halves. Character space either uses each of eight registers as a 1 KB bank, extended with two high bits from the outer-bank register, or pairs four registers into 2 KB banks. Two static configuration inputs choose the character granularity. Every output is a combinational function of the registers and configuration inputs, truncated to the fitted ROM size.

Top module: `bank_mapper`

## Requirements
- R1: A synchronous active-high reset clears every register. Mirroring then reads 0, program windows 0 to 2 read bank 0, window 3 reads the last 8 KB bank, and every character window reads 0 unless 2 KB mode is active.
- R2: `mirror` equals mode register bits 1:0. The encoding is 0 vertical, 1 horizontal, 2 single-screen A, 3 single-screen B.
- R3: With mode bit 6 clear, program windows 0, 1 and 2 take the 8 KB bank from bank registers 8, 9 and 10. Window 3 takes the last 8 KB bank, PRG_BANKS_8K-1.
- R4: With mode bit 6 set, windows 0 and 1 form a 16 KB half numbered (outer AND 0x3F). Windows 2 and 3 form a 16 KB half numbered ((outer AND 0x30) OR 0x0F). Even windows give 2×half and odd windows give 2×half+1, counted in 8 KB banks.
- R5: In 1 KB character mode, window i (0 to 7) takes bank ((outer << 4) AND 0x300) OR register i.
- R6: 2 KB character mode is active when `cfg_chr2k` is 1 and `cfg_chr2k_off` is 0. The four 2 KB regions take registers 0, 1, 6 and 7 in that order. Window 2k gives 2×reg and window 2k+1 gives 2×reg+1, in 1 KB banks.
- R7: When `cfg_chr2k_off` is 1, 1 KB mode (R5) applies even if `cfg_chr2k` is 1.
- R8: Writes decode as follows: address 0 to 10 loads that bank register, 0x10 loads the mode register and 0x11 loads the outer-bank register. Writes to any other address, or with `wr_en` low, change nothing.
- R9: Each bank output is reduced modulo the fitted size. Program outputs are taken modulo PRG_BANKS_8K and character outputs modulo CHR_BANKS_1K, both powers of two.
- R10: A write accepted at a clock edge is visible on the outputs right after that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register select (0..10 bank, 0x10 mode, 0x11 outer) |
| wr_data | input | 8 | Write data |
| cfg_chr2k | input | 1 | Request 2 KB character banking |
| cfg_chr2k_off | input | 1 | Force 1 KB character banking |
| prg_bank | output | 4×PRG_W | 8 KB bank number per program window, window 0 lowest |
| chr_bank | output | 8×CHR_W | 1 KB bank number per character window, window 0 lowest |
| mirror | output | 2 | Mirroring select |

## Verification
The assertions assume the configuration inputs change only between clock edges. They also assume both fitted sizes are powers of two of at least two banks, so that the pairing relations hold after truncation. The stimulus drives every input one nanosecond after a rising edge and holds it for a full cycle. It sets the configuration flags only between write bursts. The bench instance uses a 32-bank program ROM and a 512-bank character ROM, so the outer-bank bits and the 8-bit registers really overflow the fitted size and the truncation is exercised.

// File: rtl/bank_mapper_pkg.sv
`timescale 1ns/1ps
package bank_mapper_pkg;

    localparam int WR_ADDR_W     = 5;
    localparam int NUM_BANK_REGS = 11;
    localparam int NUM_CHR_REGS  = 8;
    localparam int NUM_PRG_WIN   = 4;
    localparam int NUM_CHR_WIN   = 8;

    localparam logic [WR_ADDR_W-1:0] MODE_ADDR  = 5'h10;
    localparam logic [WR_ADDR_W-1:0] OUTER_ADDR = 5'h11;

    typedef enum logic [1:0] {
        MIR_VERT     = 2'd0,
        MIR_HORZ     = 2'd1,
        MIR_SCREEN_A = 2'd2,
        MIR_SCREEN_B = 2'd3
    } mirror_e;

    typedef struct packed {
        mirror_e mirror;
        logic    prg_pair16;
    } mode_t;

    typedef struct packed {
        mode_t                          mode;
        logic [5:0]                     outer;
        logic [NUM_BANK_REGS-1:0][7:0]  bank;
    } map_state_t;

    // Registers feeding each 2 KB character region: 0, 1, 6, 7
    function automatic int chr_pair_source(int region);
        return (region < 2) ? region : region + 4;
    endfunction

    function automatic logic addr_is_live(logic [WR_ADDR_W-1:0] a);
        return (a < WR_ADDR_W'(NUM_BANK_REGS)) || (a == MODE_ADDR) || (a == OUTER_ADDR);
    endfunction

endpackage

// File: rtl/bm_regfile.sv
`timescale 1ns/1ps
module bm_regfile
    import bank_mapper_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [WR_ADDR_W-1:0] wr_addr,
    input  logic [7:0]           wr_data,
    output map_state_t           state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (wr_en) begin
            if (wr_addr == MODE_ADDR) begin
                state.mode.mirror     <= mirror_e'(wr_data[1:0]);
                state.mode.prg_pair16 <= wr_data[6];
            end else if (wr_addr == OUTER_ADDR) begin
                state.outer <= wr_data[5:0];
            end else begin
                for (int r = 0; r < NUM_BANK_REGS; r++) begin
                    if (wr_addr == WR_ADDR_W'(r)) begin
                        state.bank[r] <= wr_data;
                    end
                end
            end
        end
    end

    // R8: a disabled write or a stray address leaves all state untouched
    a_r8_stray_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || !addr_is_live(wr_addr)) |=> $stable(state));

endmodule

// File: rtl/bm_prg_gen.sv
`timescale 1ns/1ps
module bm_prg_gen
    import bank_mapper_pkg::*;
#(
    parameter int PRG_BANKS_8K = 64,
    parameter int PRG_W        = 6
) (
    input  logic                              pair16,
    input  logic [5:0]                        outer,
    input  logic [2:0][7:0]                   sel8k,
    output logic [NUM_PRG_WIN-1:0][PRG_W-1:0] prg
);

    localparam logic [PRG_W-1:0] LAST_BANK = PRG_W'(PRG_BANKS_8K - 1);

    for (genvar w = 0; w < NUM_PRG_WIN; w++) begin : g_win
        logic [7:0]       half16;
        logic [PRG_W-1:0] paired;
        logic [PRG_W-1:0] single;

        if (w < 2) begin : g_low
            assign half16 = {2'b00, outer};
        end else begin : g_high
            assign half16 = {2'b00, outer[5:4], 4'hF};
        end

        assign paired = PRG_W'(int'(half16) * 2 + (w % 2));

        if (w < 3) begin : g_free
            assign single = PRG_W'(int'(sel8k[w]));
        end else begin : g_fixed
            assign single = LAST_BANK;
        end

        assign prg[w] = pair16 ? paired : single;
    end

endmodule

// File: rtl/bm_chr_gen.sv
`timescale 1ns/1ps
module bm_chr_gen
    import bank_mapper_pkg::*;
#(
    parameter int CHR_BANKS_1K = 1024,
    parameter int CHR_W        = 10
) (
    input  logic                              two_k,
    input  logic [1:0]                        outer_hi,
    input  logic [NUM_CHR_REGS-1:0][7:0]      regs,
    output logic [NUM_CHR_WIN-1:0][CHR_W-1:0] chr
);

    for (genvar i = 0; i < NUM_CHR_WIN; i++) begin : g_win
        localparam int SRC = chr_pair_source(i / 2);
        logic [CHR_W-1:0] fine_bank;
        logic [CHR_W-1:0] pair_bank;

        assign fine_bank = CHR_W'(int'({outer_hi, regs[i]}));
        assign pair_bank = CHR_W'(int'(regs[SRC]) * 2 + (i % 2));
        assign chr[i]    = two_k ? pair_bank : fine_bank;
    end

endmodule

// File: rtl/bank_mapper.sv
`timescale 1ns/1ps
module bank_mapper
    import bank_mapper_pkg::*;
#(
    parameter int PRG_BANKS_8K = 64,
    parameter int CHR_BANKS_1K = 1024,
    localparam int PRG_W = $clog2(PRG_BANKS_8K),
    localparam int CHR_W = $clog2(CHR_BANKS_1K)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [4:0]                        wr_addr,
    input  logic [7:0]                        wr_data,
    input  logic                              cfg_chr2k,
    input  logic                              cfg_chr2k_off,
    output logic [NUM_PRG_WIN-1:0][PRG_W-1:0] prg_bank,
    output logic [NUM_CHR_WIN-1:0][CHR_W-1:0] chr_bank,
    output logic [1:0]                        mirror
);

    map_state_t state;
    logic       chr_two_k;

    bm_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .state   (state)
    );

    bm_prg_gen #(
        .PRG_BANKS_8K (PRG_BANKS_8K),
        .PRG_W        (PRG_W)
    ) u_prg (
        .pair16 (state.mode.prg_pair16),
        .outer  (state.outer),
        .sel8k  (state.bank[10:8]),
        .prg    (prg_bank)
    );

    assign chr_two_k = cfg_chr2k && !cfg_chr2k_off;

    bm_chr_gen #(
        .CHR_BANKS_1K (CHR_BANKS_1K),
        .CHR_W        (CHR_W)
    ) u_chr (
        .two_k    (chr_two_k),
        .outer_hi (state.outer[5:4]),
        .regs     (state.bank[7:0]),
        .chr      (chr_bank)
    );

    assign mirror = state.mode.mirror;

    // R10: a mode write shows on the mirroring output right after the edge
    a_r10_mode_visible: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == MODE_ADDR) |=> (mirror == $past(wr_data[1:0])));

    // R2: mirroring moves only on a mode write
    a_r2_mirror_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == MODE_ADDR) |=> $stable(mirror));

    // R4: in paired layout each 16 KB half is an even/odd 8 KB couple
    for (genvar h = 0; h < 2; h++) begin : g_prg_chk
        a_r4_half_pairing: assert property (@(posedge clk) disable iff (rst)
            state.mode.prg_pair16 |->
                (prg_bank[2*h][0] == 1'b0) && (prg_bank[2*h+1] == (prg_bank[2*h] | PRG_W'(1))));
    end

    // R6: in 2 KB mode each region is an even/odd 1 KB couple
    for (genvar p = 0; p < 4; p++) begin : g_chr_chk
        a_r6_region_pairing: assert property (@(posedge clk) disable iff (rst)
            chr_two_k |->
                (chr_bank[2*p][0] == 1'b0) && (chr_bank[2*p+1] == (chr_bank[2*p] | CHR_W'(1))));
    end

    // R5: in 1 KB mode all windows share the outer-derived high bits
    if (CHR_W > 8) begin : g_chr_high_chk
        for (genvar i = 1; i < NUM_CHR_WIN; i++) begin : g_win
            a_r5_shared_high_bits: assert property (@(posedge clk) disable iff (rst)
                !chr_two_k |-> (chr_bank[i][CHR_W-1:8] == chr_bank[0][CHR_W-1:8]));
        end
    end

endmodule

// File: tb/tb_bank_mapper.sv
`timescale 1ns/1ps
module tb_bank_mapper;

    localparam int PRG_N = 32;
    localparam int CHR_N = 512;
    localparam int PW    = $clog2(PRG_N);
    localparam int CW    = $clog2(CHR_N);

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                wr_en = 1'b0;
    logic [4:0]          wr_addr = '0;
    logic [7:0]          wr_data = '0;
    logic                cfg_chr2k = 1'b0;
    logic                cfg_chr2k_off = 1'b0;
    logic [3:0][PW-1:0]  prg_bank;
    logic [7:0][CW-1:0]  chr_bank;
    logic [1:0]          mirror;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    bit cmp_on = 1'b0;

    // behavioural reference state
    int m_bank[11];
    int m_mode;
    int m_outer;
    bit m_wrote;

    bank_mapper #(.PRG_BANKS_8K(PRG_N), .CHR_BANKS_1K(CHR_N)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_chr2k(cfg_chr2k), .cfg_chr2k_off(cfg_chr2k_off),
        .prg_bank(prg_bank), .chr_bank(chr_bank), .mirror(mirror)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        m_wrote = 1'b0;
        if (rst) begin
            foreach (m_bank[k]) m_bank[k] = 0;
            m_mode  = 0;
            m_outer = 0;
        end else if (wr_en) begin
            if (wr_addr == 5'h10) begin
                m_mode = wr_data; m_wrote = 1'b1;
            end else if (wr_addr == 5'h11) begin
                m_outer = wr_data; m_wrote = 1'b1;
            end else if (wr_addr < 11) begin
                m_bank[wr_addr] = wr_data; m_wrote = 1'b1;
            end
        end
    end

    function automatic int exp_prg(int w);
        int half;
        if (m_mode & 'h40) begin
            half = (w < 2) ? (m_outer & 'h3F) : ((m_outer & 'h30) | 'h0F);
            return (half * 2 + w % 2) % PRG_N;
        end
        if (w == 3) return PRG_N - 1;
        return m_bank[8 + w] % PRG_N;
    endfunction

    function automatic bit two_k_on();
        return cfg_chr2k && !cfg_chr2k_off;
    endfunction

    function automatic int exp_chr(int i);
        int src;
        if (two_k_on()) begin
            src = (i / 2 < 2) ? i / 2 : i / 2 + 4;
            return (m_bank[src] * 2 + i % 2) % CHR_N;
        end
        return (((m_outer << 4) & 'h300) | m_bank[i]) % CHR_N;
    endfunction

    task automatic chk(input int got, input int exp, input string req, input string what);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && cmp_on) begin
            string sfx;
            sfx = m_wrote ? "/R10" : "";
            for (int w = 0; w < 4; w++)
                chk(int'(prg_bank[w]), exp_prg(w), {((m_mode & 'h40) != 0) ? "R4" : "R3", sfx},
                    $sformatf("prg window %0d", w));
            for (int i = 0; i < 8; i++)
                chk(int'(chr_bank[i]), exp_chr(i),
                    {two_k_on() ? "R6" : (cfg_chr2k ? "R7" : "R5"), sfx},
                    $sformatf("chr window %0d", i));
            chk(int'(mirror), m_mode & 3, {"R2", sfx}, "mirror");
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic check_reset_state(input string tag);
        @(negedge clk);
        for (int w = 0; w < 3; w++) chk(int'(prg_bank[w]), 0, "R1", {tag, " prg low windows"});
        chk(int'(prg_bank[3]), PRG_N - 1, "R1", {tag, " prg last window"});
        for (int i = 0; i < 8; i++) chk(int'(chr_bank[i]), 0, "R1", {tag, " chr window"});
        chk(int'(mirror), 0, "R1", {tag, " mirror"});
    endtask

    initial begin
        logic [3:0][PW-1:0] snap_p;
        logic [7:0][CW-1:0] snap_c;
        logic [1:0]         snap_m;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        cmp_on = 1'b1;
        check_reset_state("first");

        // R3 / R5 / R9: free layout and 1 KB mode with overflow
        wr(8, 'hE5); wr(0, 'h12); wr(6, 'hFF); wr(5'h11, 'h3F);
        @(negedge clk);
        chk(int'(prg_bank[0]), 5, "R9", "8 KB bank 0xE5 truncated");
        chk(int'(prg_bank[3]), 31, "R3", "fixed last window");
        chk(int'(chr_bank[0]), 274, "R9", "1 KB bank 0x312 truncated");

        // R4 / R9: paired layout with outer 0x3F
        wr(5'h10, 'h40);
        @(negedge clk);
        chk(int'(prg_bank[0]), 30, "R4", "lower half even");
        chk(int'(prg_bank[1]), 31, "R4", "lower half odd");
        chk(int'(prg_bank[2]), 30, "R9", "upper half even");
        chk(int'(prg_bank[3]), 31, "R9", "upper half odd");

        // R6: 2 KB pairing
        @(posedge clk); #1 cfg_chr2k = 1'b1;
        @(negedge clk);
        chk(int'(chr_bank[0]), 36, "R6", "region0 even");
        chk(int'(chr_bank[1]), 37, "R6", "region0 odd");
        chk(int'(chr_bank[4]), 510, "R6", "region2 even from reg6");
        chk(int'(chr_bank[5]), 511, "R6", "region2 odd from reg6");

        // R7: override returns to 1 KB mode
        @(posedge clk); #1 cfg_chr2k_off = 1'b1;
        @(negedge clk);
        chk(int'(chr_bank[4]), 256, "R7", "window4 in forced 1 KB");
        chk(int'(chr_bank[0]), 274, "R7", "window0 in forced 1 KB");

        // R2: all four mirroring codes
        for (int v = 1; v < 4; v++) begin
            wr(5'h10, v);
            @(negedge clk);
            chk(int'(mirror), v, "R2", "mirror code");
        end
        chk(int'(prg_bank[0]), 5, "R3", "back to free layout");
        wr(5'h10, 'h43);
        @(negedge clk);
        chk(int'(mirror), 3, "R2", "mirror with layout bit");

        // R8: stray addresses and disabled writes
        @(negedge clk);
        snap_p = prg_bank; snap_c = chr_bank; snap_m = mirror;
        wr(11, 'hFF); wr(15, 'hFF); wr(5'h12, 'hFF); wr(5'h1F, 'hFF);
        @(posedge clk); #1 wr_addr = 5'd8; wr_data = 8'h00; wr_en = 1'b0;
        @(posedge clk); #1 wr_addr = 5'h10;
        @(posedge clk); #1;
        @(negedge clk);
        chk(int'(prg_bank), int'(snap_p), "R8", "prg after ignored writes");
        chk(int'(chr_bank), int'(snap_c), "R8", "chr after ignored writes");
        chk(int'(mirror), int'(snap_m), "R8", "mirror after ignored writes");

        // mixed traffic
        for (int n = 0; n < 600; n++) begin
            if (n % 50 == 0) begin
                @(posedge clk); #1;
                cfg_chr2k = 1'($urandom); cfg_chr2k_off = 1'($urandom);
            end
            wr(int'($urandom % 32), int'($urandom % 256));
        end

        // R1 again after a mid-run reset
        @(posedge clk); #1;
        cfg_chr2k = 1'b0; cfg_chr2k_off = 1'b0; rst = 1'b1;
        @(posedge clk); @(posedge clk); #1 rst = 1'b0;
        check_reset_state("second");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule